// File: doc/BRIEF.md
# Programmable Pulse Generator Timer

This block produces a periodic square wave on a single output pin. A 16-bit up-counter advances on every clock in which the count-enable input is high. Two compare values steer it. A match against the period value clears the counter back to zero, so one period lasts (period value + 1) counted clocks. A match against the width value marks where the pulse edge falls inside the period.

The pin level does not come from comparing the counter against a threshold. An output flip-flop inverts on every compare match, and it starts from a level that software loads while the counter is stopped. With a starting level of one, the pin is high for (width value + 1) counted clocks of every (period value + 1), which gives a duty ratio of (width + 1)/(period + 1). Valid settings satisfy 0 < width < period. An output-enable bit gates the pin and holds it low when clear. Both compare values are used directly on the next comparison; they are not double-buffered. The block has no one-shot mode: it runs continuously.

Top module: `ppg_timer`

## Requirements
- R1: While `rst` is high and at the first clock after it, the counter is zero, the flip-flop level is 0, `pin` is 0 and both match strobes are 0.
- R2: The counter advances by one on each clock with `run` high and holds its value while `run` is low; both strobes are 0 while `run` is low.
- R3: `period_hit` is high in a cycle with `run` high and counter equal to `period_val`; at that clock edge the counter returns to 0, so the pattern repeats every `period_val`+1 counted clocks.
- R4: `width_hit` is high in a cycle with `run` high, counter equal to `width_val` and counter not equal to `period_val`.
- R5: The flip-flop level inverts at each clock edge where either strobe is high and is unchanged at other running edges; with starting level 1 and valid settings the pin is high for `width_val`+1 of every `period_val`+1 counted clocks.
- R6: When both compare values equal the counter in the same cycle, only the period match counts: `period_hit` is 1, `width_hit` is 0 and the level inverts once.
- R7: While `run` is low, `lvl_set`=1 loads level 1 at the next edge and `lvl_clr`=1 alone loads level 0; if both are high, set wins. While `run` is high, both inputs are ignored.
- R8: `pin` equals the flip-flop level when `out_en` is 1 and is 0 when `out_en` is 0; the flip-flop keeps toggling while the pin is gated.
- R9: A new `period_val` or `width_val` is used in the comparison of the very next cycle, with no buffering.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Count enable |
| period_val | input | 16 | Period compare value |
| width_val | input | 16 | Width compare value |
| out_en | input | 1 | Pin enable; pin is low when clear |
| lvl_set | input | 1 | Load level 1 while stopped |
| lvl_clr | input | 1 | Load level 0 while stopped |
| pin | output | 1 | Pulse output |
| period_hit | output | 1 | Period match strobe |
| width_hit | output | 1 | Width match strobe |

## Verification
The bench runs several period and width pairs: 9/3 from a starting level of one, 4/1 from level zero, the smallest valid pair 2/1, and equal values 5/5. Together these separate the correct duty from off-by-one wrap points, inverted start levels and a double toggle on simultaneous matches. Pauses in the middle of a period show whether the counter holds or drifts. Level-load inputs pulsed during a run show whether they are wrongly taken in. A gated pin followed by re-enable shows that toggling goes on behind the gate, and rewriting the period in the middle of a run tells immediate use apart from a value that waits for the next wrap.

// File: rtl/ppg_pkg.sv
package ppg_pkg;

    localparam int unsigned PPG_CNT_W = 16;

    typedef struct packed {
        logic period;
        logic width;
    } ppg_hit_t;

    // Next flip-flop level: toggle on a match while running,
    // load from set/clear (set first) while stopped.
    function automatic logic next_level(
        input logic     cur,
        input ppg_hit_t hit,
        input logic     run,
        input logic     set,
        input logic     clr
    );
        logic nl;
        nl = cur;
        if (run) begin
            if (hit.period || hit.width) nl = ~cur;
        end else if (set) begin
            nl = 1'b1;
        end else if (clr) begin
            nl = 1'b0;
        end
        return nl;
    endfunction

endpackage

// File: rtl/ppg_counter.sv
module ppg_counter
    import ppg_pkg::*;
#(
    parameter int unsigned CNT_W = PPG_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [CNT_W-1:0] period_val,
    input  logic [CNT_W-1:0] width_val,
    output ppg_hit_t         hit
);
    localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
    localparam logic [CNT_W-1:0] ZERO = '0;

    logic [CNT_W-1:0] cnt;
    logic             eq_period;
    logic             eq_width;

    always_comb begin
        eq_period  = (cnt == period_val);
        eq_width   = (cnt == width_val);
        hit.period = run & eq_period;
        hit.width  = run & eq_width & ~eq_period;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= ZERO;
        end else if (run) begin
            cnt <= eq_period ? ZERO : cnt + ONE;
        end
    end

    // R3: a period match sends the counter back to zero
    p_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        hit.period |=> (cnt == ZERO));

    // R2: counting step of one when no wrap
    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        (run && !hit.period) |=> (cnt == $past(cnt) + ONE));

    // R2: counter holds while stopped
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !run |=> $stable(cnt));

endmodule

// File: rtl/ppg_outff.sv
module ppg_outff
    import ppg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     run,
    input  logic     lvl_set,
    input  logic     lvl_clr,
    input  ppg_hit_t hit,
    output logic     level
);
    always_ff @(posedge clk) begin
        if (rst) begin
            level <= 1'b0;
        end else begin
            level <= next_level(level, hit, run, lvl_set, lvl_clr);
        end
    end

    // R5: every match inverts the level
    p_toggle_r5: assert property (@(posedge clk) disable iff (rst)
        (hit.period || hit.width) |=> (level != $past(level)));

    // R7: set/clear have no effect while running without a match
    p_runhold_r7: assert property (@(posedge clk) disable iff (rst)
        (run && !hit.period && !hit.width) |=> $stable(level));

endmodule

// File: rtl/ppg_timer.sv
module ppg_timer
    import ppg_pkg::*;
#(
    parameter int unsigned CNT_W = PPG_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [CNT_W-1:0] period_val,
    input  logic [CNT_W-1:0] width_val,
    input  logic             out_en,
    input  logic             lvl_set,
    input  logic             lvl_clr,
    output logic             pin,
    output logic             period_hit,
    output logic             width_hit
);
    ppg_hit_t hit;
    logic     level;

    ppg_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .run        (run),
        .period_val (period_val),
        .width_val  (width_val),
        .hit        (hit)
    );

    ppg_outff u_ff (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .lvl_set (lvl_set),
        .lvl_clr (lvl_clr),
        .hit     (hit),
        .level   (level)
    );

    always_comb begin
        period_hit = hit.period;
        width_hit  = hit.width;
        pin        = out_en & level;
    end

    // R6: the two strobes never fire together
    p_excl_r6: assert property (@(posedge clk) disable iff (rst)
        period_hit |-> !width_hit);

    // R2: no strobes while stopped
    p_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !run |-> (!period_hit && !width_hit));

endmodule

// File: tb/ppg_timer_test.sv
module ppg_timer_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run = 1'b0;
    logic [15:0] period_val = 16'd9;
    logic [15:0] width_val  = 16'd3;
    logic        out_en  = 1'b0;
    logic        lvl_set = 1'b0;
    logic        lvl_clr = 1'b0;
    logic        pin, period_hit, width_hit;

    always #4 clk = ~clk;

    ppg_timer uut (
        .clk(clk), .rst(rst), .run(run),
        .period_val(period_val), .width_val(width_val),
        .out_en(out_en), .lvl_set(lvl_set), .lvl_clr(lvl_clr),
        .pin(pin), .period_hit(period_hit), .width_hit(width_hit)
    );

    typedef struct {
        logic  pin;
        logic  ph;
        logic  wh;
        string tag;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // bench-side view of where the period stands and what the level is
    int unsigned phase = 0;
    logic        lvl_m = 1'b0;

    task automatic do_reset(string tag);
        @(posedge clk); #2;
        rst = 1'b1; run = 1'b0; lvl_set = 1'b0; lvl_clr = 1'b0;
        @(posedge clk); #2;
        @(posedge clk); #2;
        rst = 1'b0;
        phase = 0; lvl_m = 1'b0;
        q.push_back('{pin: 1'b0, ph: 1'b0, wh: 1'b0, tag: tag});
    endtask

    task automatic step(input logic r, input logic s, input logic c,
                        input logic en, input string tag);
        exp_t e;
        logic hp, hw;
        @(posedge clk); #2;
        run = r; lvl_set = s; lvl_clr = c; out_en = en;
        hp = r && (phase == period_val);
        hw = r && (phase == width_val) && !hp;
        e.pin = en & lvl_m; e.ph = hp; e.wh = hw; e.tag = tag;
        q.push_back(e);
        if (r) begin
            phase = hp ? 0 : phase + 1;
            if (hp || hw) lvl_m = ~lvl_m;
        end else if (s) begin
            lvl_m = 1'b1;
        end else if (c) begin
            lvl_m = 1'b0;
        end
    endtask

    task automatic run_n(int n, logic en, logic noise, string tag);
        for (int i = 0; i < n; i++)
            step(1'b1, noise & i[0], noise & ~i[0], en, tag);
    endtask

    // monitor: pop the expected item for this cycle and compare
    initial begin
        forever begin
            @(posedge clk); #4;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (pin !== e.pin || period_hit !== e.ph || width_hit !== e.wh) begin
                    fails++;
                    $display("FAIL %s: pin/period_hit/width_hit actual %b%b%b expected %b%b%b",
                             e.tag, pin, period_hit, width_hit, e.pin, e.ph, e.wh);
                end
            end
        end
    end

    initial begin
        // R1 reset state
        do_reset("R1");
        step(1'b0, 1'b0, 1'b0, 1'b1, "R1");

        // R7 load level 1, then R3/R4/R5 with 9/3
        period_val = 16'd9; width_val = 16'd3;
        step(1'b0, 1'b1, 1'b0, 1'b1, "R7");
        run_n(25, 1'b1, 1'b0, "R5");
        // R2 pause mid-period, then resume
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b0, 1'b1, "R2");
        run_n(12, 1'b1, 1'b0, "R3");

        // R7 level 0 via clear, set/clear noise while running, pair 4/1
        do_reset("R1");
        period_val = 16'd4; width_val = 16'd1;
        step(1'b0, 1'b1, 1'b0, 1'b1, "R7");
        step(1'b0, 1'b0, 1'b1, 1'b1, "R7");
        run_n(16, 1'b1, 1'b1, "R7");
        // R7 set wins over clear while stopped
        step(1'b0, 1'b1, 1'b1, 1'b1, "R7");
        step(1'b0, 1'b0, 1'b0, 1'b1, "R7");
        run_n(7, 1'b1, 1'b0, "R4");

        // R8 gated pin, toggling continues behind the gate
        run_n(9, 1'b0, 1'b0, "R8");
        run_n(9, 1'b1, 1'b0, "R8");

        // R6 equal compare values
        do_reset("R1");
        period_val = 16'd5; width_val = 16'd5;
        step(1'b0, 1'b1, 1'b0, 1'b1, "R6");
        run_n(14, 1'b1, 1'b0, "R6");

        // R9 period rewritten mid-run takes effect at once
        do_reset("R1");
        period_val = 16'd20; width_val = 16'd2;
        step(1'b0, 1'b1, 1'b0, 1'b1, "R9");
        run_n(5, 1'b1, 1'b0, "R9");
        period_val = 16'd7;
        run_n(12, 1'b1, 1'b0, "R9");
        width_val = 16'd5;
        run_n(12, 1'b1, 1'b0, "R9");

        // smallest valid pair
        do_reset("R1");
        period_val = 16'd2; width_val = 16'd1;
        step(1'b0, 1'b1, 1'b0, 1'b1, "R5");
        run_n(10, 1'b1, 1'b0, "R3");

        @(posedge clk); @(posedge clk); #6;
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        #800000;
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule